// File: doc/BRIEF.md
# MSI Doorbell Device-ID Tagger

This block sits between a simple memory-mapped write bus and an interrupt translation unit. Bus masters raise message-signalled interrupts by writing an event value to a doorbell. The masters do not carry their own identity, so the block works out a device identifier from the address each write hits.

A dedicated aliasing window gives every device its own 32-bit word slot. The slot index within the window becomes the device identifier. A write aimed straight at the translation register is tagged with identifier zero. Each accepted doorbell write becomes one request on a valid/ready output that carries the identifier and the written event value.

When the output is stalled, the block lowers the bus ready signal, so no doorbell is lost. Both the window base and the translation register address are configuration inputs.

Top module: `msi_id_tagger`

## Requirements
- R1: A full-word write (bus_be = 4'b1111) that lands in the window raises req_valid on the next clock edge. It carries req_devid = bus_addr[ID_BITS+1:2] and req_event = bus_wdata.
- R2: The window covers 4 << ID_BITS bytes, so it holds 2**ID_BITS one-word slots. A write hits the window when bus_addr[ADDR_W-1:ID_BITS+2] equals cfg_win_base[ADDR_W-1:ID_BITS+2]. The low ID_BITS+2 bits of cfg_win_base are ignored.
- R3: A full-word write to the translation register produces a request with req_devid = 0 and req_event = bus_wdata. The register is hit when bus_addr[ADDR_W-1:2] equals cfg_xlat_addr[ADDR_W-1:2].
- R4: A window write whose bus_be is not 4'b1111 produces no request. It raises size_err for exactly one cycle, on the clock edge after the write is accepted.
- R5: A translation-register write whose bus_be is not 4'b1111 is dropped with no request and no size_err.
- R6: A write that hits neither the window nor the translation register produces no request and no size_err.
- R7: Reads (bus_write = 0) always see bus_rdata = 0 and never produce a request.
- R8: While req_valid is high and req_ready is low, bus_ready is low. During that time req_devid and req_event hold steady.
- R9: With req_ready high, writes accepted on consecutive cycles produce requests on consecutive cycles. A new write is accepted in the same cycle that the previous request is consumed.
- R10: While rst_n is low at a clock edge, req_valid and size_err are cleared.
- R11: If an address hits both the window and the translation register, the window decode wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_win_base | input | ADDR_W | Base address of the aliasing window |
| cfg_xlat_addr | input | ADDR_W | Address of the translation register |
| bus_valid | input | 1 | Bus transfer request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_ready | output | 1 | Transfer accepted when high together with bus_valid |
| bus_rdata | output | 32 | Read data, always zero |
| req_valid | output | 1 | Tagged request pending |
| req_ready | input | 1 | Downstream accepts request |
| req_devid | output | ID_BITS | Device identifier |
| req_event | output | 32 | Event value |
| size_err | output | 1 | One-cycle pulse on a partial window write |

## Verification
A wrong slot decode shows up at req_devid one cycle after the write, for example as a neighbouring slot index or a nonzero identifier on a direct write. The bench therefore writes the first and last slots, the word just past the window, and a misaligned configured base. A stale output register or missed backpressure would either let bus_ready rise during a stall or change req_devid while it waits. Both are visible within the stall itself, and the stalled request is checked for several cycles before the release. A decode that leaks reads or partial writes would show a spurious req_valid or size_err on the cycle after the transfer.

// File: rtl/msi_id_tagger.sv
module msi_id_tagger #(
  parameter int ADDR_W  = 32,
  parameter int ID_BITS = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  cfg_win_base,
  input  logic [ADDR_W-1:0]  cfg_xlat_addr,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  input  logic [3:0]         bus_be,
  output logic               bus_ready,
  output logic [31:0]        bus_rdata,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [ID_BITS-1:0] req_devid,
  output logic [31:0]        req_event,
  output logic               size_err
);
  localparam int WIN_LG = ID_BITS + 2;

  logic wr, win_hit, xlat_hit, full, take_win, take_xlat, bad;

  assign bus_ready = !(req_valid && !req_ready);
  assign bus_rdata = '0;

  assign wr       = bus_valid && bus_ready && bus_write;
  assign win_hit  = bus_addr[ADDR_W-1:WIN_LG] == cfg_win_base[ADDR_W-1:WIN_LG];
  assign xlat_hit = bus_addr[ADDR_W-1:2] == cfg_xlat_addr[ADDR_W-1:2];
  assign full     = &bus_be;

  assign take_win  = wr && win_hit && full;
  assign take_xlat = wr && !win_hit && xlat_hit && full;
  assign bad       = wr && win_hit && !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      size_err  <= 1'b0;
    end else begin
      size_err <= bad;
      if (take_win || take_xlat) begin
        req_valid <= 1'b1;
        req_event <= bus_wdata;
        req_devid <= take_win ? bus_addr[WIN_LG-1:2] : '0;
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/msi_id_tagger_chk.sv
module msi_id_tagger_chk #(
  parameter int ID_BITS = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_valid,
  input logic               bus_write,
  input logic               bus_ready,
  input logic [31:0]        bus_rdata,
  input logic               req_valid,
  input logic               req_ready,
  input logic [ID_BITS-1:0] req_devid,
  input logic [31:0]        req_event,
  input logic               size_err
);
  p_stall_blocks_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> !bus_ready);

  p_stall_holds_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_devid) && $stable(req_event)));

  p_read_no_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_ready && !bus_write) |=> !req_valid);

  p_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata == 32'd0);

  p_err_from_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> $past(bus_valid && bus_ready && bus_write));

  p_err_no_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    size_err |-> !req_valid);
endmodule

bind msi_id_tagger msi_id_tagger_chk #(.ID_BITS(ID_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_ready(bus_ready), .bus_rdata(bus_rdata), .req_valid(req_valid),
  .req_ready(req_ready), .req_devid(req_devid), .req_event(req_event),
  .size_err(size_err)
);

// File: tb/msi_id_tagger_test.sv
module msi_id_tagger_test;
  localparam int ADDR_W = 32;
  localparam int ID_BITS = 8;
  localparam logic [31:0] WBASE = 32'h0001_0000;
  localparam logic [31:0] XADDR = 32'h0002_0040;

  logic clk = 0, rst_n = 0;
  logic [31:0] cfg_win_base = WBASE, cfg_xlat_addr = XADDR;
  logic bus_valid = 0, bus_write = 0, req_ready = 1;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [3:0] bus_be = 0;
  logic bus_ready, req_valid, size_err;
  logic [31:0] bus_rdata, req_event;
  logic [ID_BITS-1:0] req_devid;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  msi_id_tagger #(.ADDR_W(ADDR_W), .ID_BITS(ID_BITS)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_win_base(cfg_win_base), .cfg_xlat_addr(cfg_xlat_addr),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_devid(req_devid), .req_event(req_event), .size_err(size_err));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = a; bus_wdata = d; bus_be = be;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic expect_req(input string tag, input logic [ID_BITS-1:0] id, input logic [31:0] ev);
    chk(req_valid === 1'b1, {tag, " valid"}, 32'(req_valid), 1);
    chk(req_devid === id, {tag, " devid"}, 32'(req_devid), 32'(id));
    chk(req_event === ev, {tag, " event"}, req_event, ev);
  endtask

  task automatic expect_none(input string tag);
    chk(req_valid === 1'b0, {tag, " no req"}, 32'(req_valid), 0);
    chk(size_err === 1'b0, {tag, " no err"}, 32'(size_err), 0);
  endtask

  task automatic t_reset();
    chk(req_valid === 1'b0, "R10 reset valid", 32'(req_valid), 0);
    chk(size_err === 1'b0, "R10 reset err", 32'(size_err), 0);
    chk(bus_ready === 1'b1, "R10 reset ready", 32'(bus_ready), 1);
  endtask

  task automatic t_window();
    drive(1, WBASE + (32'h5A << 2), 32'hCAFE_0001, 4'hF); idle();
    expect_req("R1 mid slot", 8'h5A, 32'hCAFE_0001);
    drive(1, WBASE, 32'h0000_0011, 4'hF); idle();
    expect_req("R2 first slot", 8'h00, 32'h0000_0011);
    drive(1, WBASE + 32'h3FC, 32'h0000_0022, 4'hF); idle();
    expect_req("R2 last slot", 8'hFF, 32'h0000_0022);
    drive(1, WBASE + 32'h400, 32'h0000_0033, 4'hF); idle();
    expect_none("R2 past window");
    cfg_win_base = WBASE | 32'h123;
    drive(1, WBASE + (32'h07 << 2), 32'h0000_0044, 4'hF); idle();
    expect_req("R2 base low bits ignored", 8'h07, 32'h0000_0044);
    cfg_win_base = WBASE;
  endtask

  task automatic t_xlat();
    drive(1, XADDR, 32'h1234_5678, 4'hF); idle();
    expect_req("R3 direct", 8'h00, 32'h1234_5678);
    drive(1, XADDR, 32'h0000_0055, 4'h3); idle();
    expect_none("R5 partial direct");
  endtask

  task automatic t_partial();
    drive(1, WBASE + 32'h10, 32'h0000_0066, 4'h1); idle();
    chk(size_err === 1'b1, "R4 err pulse", 32'(size_err), 1);
    chk(req_valid === 1'b0, "R4 no req", 32'(req_valid), 0);
    @(negedge clk);
    chk(size_err === 1'b0, "R4 err one cycle", 32'(size_err), 0);
  endtask

  task automatic t_miss_and_read();
    drive(1, 32'h0003_0000, 32'h0000_0077, 4'hF); idle();
    expect_none("R6 miss");
    drive(0, WBASE + 32'h20, 32'h0, 4'hF);
    #1 chk(bus_rdata === 32'h0, "R7 rdata window", bus_rdata, 0);
    idle();
    expect_none("R7 read window");
    drive(0, XADDR, 32'h0, 4'hF);
    #1 chk(bus_rdata === 32'h0, "R7 rdata xlat", bus_rdata, 0);
    idle();
    expect_none("R7 read xlat");
  endtask

  task automatic t_backpressure();
    req_ready = 0;
    drive(1, WBASE + (32'h21 << 2), 32'hAAAA_0001, 4'hF);
    @(negedge clk);
    bus_addr = WBASE + (32'h42 << 2); bus_wdata = 32'hBBBB_0002;
    chk(bus_ready === 1'b0, "R8 ready low", 32'(bus_ready), 0);
    expect_req("R8 held 1", 8'h21, 32'hAAAA_0001);
    repeat (2) @(negedge clk);
    chk(bus_ready === 1'b0, "R8 ready still low", 32'(bus_ready), 0);
    expect_req("R8 held 3", 8'h21, 32'hAAAA_0001);
    req_ready = 1;
    @(negedge clk);
    bus_valid = 0;
    expect_req("R9 swap on consume", 8'h42, 32'hBBBB_0002);
    @(negedge clk);
    expect_none("R9 drained");
  endtask

  task automatic t_burst();
    drive(1, WBASE + (32'h01 << 2), 32'h0000_0101, 4'hF);
    drive(1, WBASE + (32'h02 << 2), 32'h0000_0202, 4'hF);
    expect_req("R9 burst 1", 8'h01, 32'h0000_0101);
    drive(1, XADDR, 32'h0000_0303, 4'hF);
    expect_req("R9 burst 2", 8'h02, 32'h0000_0202);
    idle();
    expect_req("R9 burst 3", 8'h00, 32'h0000_0303);
  endtask

  task automatic t_overlap();
    cfg_xlat_addr = WBASE + (32'h33 << 2);
    drive(1, WBASE + (32'h33 << 2), 32'h0000_0909, 4'hF); idle();
    expect_req("R11 window wins", 8'h33, 32'h0000_0909);
    cfg_xlat_addr = XADDR;
  endtask

  task automatic t_reset_mid();
    req_ready = 0;
    drive(1, WBASE + 32'h8, 32'h0000_0808, 4'hF); idle();
    chk(req_valid === 1'b1, "R10 pre-reset valid", 32'(req_valid), 1);
    rst_n = 0;
    @(negedge clk);
    chk(req_valid === 1'b0, "R10 mid reset valid", 32'(req_valid), 0);
    rst_n = 1; req_ready = 1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_xlat();
    t_partial();
    t_miss_and_read();
    t_backpressure();
    t_burst();
    t_overlap();
    t_reset_mid();
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule